// File: doc/BRIEF.md
# DRAM Rank Boundary Address Decoder

This block turns a physical memory address into the DRAM channel and rank that hold it. Software programs eight boundary registers, four ranks on each of two channels, plus a top-of-memory register and a strap that turns off the second channel. Each boundary is the cumulative end address of its rank in 64 MiB units, counted within its channel. The decoder compares the 64 MiB unit number of the address against those ends. It returns a registered hit flag, a channel index and a global rank index.

The same register state also gives the size of every rank in 4 KiB pages, which software reads through a rank select. When the second channel's last boundary equals top of memory, the layout is taken as stacked. In that case the second channel's numbering continues past the first channel's total, and the first channel's total is removed from the size of the second channel's final rank.

Top module: `dram_rank_decoder`

## Requirements
- R1: Register index map: indices 0 to 7 hold boundaries (index = channel*4 + rank), index 8 holds top of memory, and index 9 holds the single-channel strap in bit 0. Only bits 9:0 of a boundary or top-of-memory write are kept (bit 0 only for the strap). Reading back returns the kept value with every other bit zero, and an unused index reads zero.
- R2: After reset every register is zero, the hit flag is low, the channel and rank outputs are zero, and every rank size reads zero.
- R3: The decode is registered. The outputs for an address appear one clock edge after that address is sampled, and they hold until the next edge. A register write at one edge is used by the decode at the following edge.
- R4: The global rank index equals channel*4 plus the rank within the channel, so its bit 2 always equals the channel index.
- R5: The address unit number is physAddr[35:26]. The selected rank is the first one, in the order channel 0 rank 0..3 and then channel 1 rank 0..3, whose boundary is strictly greater than the unit number and whose size is not zero.
- R6: A unit number at or above top of memory gives hit low with channel 0 and rank 0. The same outputs appear when no rank matches.
- R7: A rank size in units is its boundary minus the previous rank's boundary in the same channel. For rank 0 the size is the boundary itself. A negative result reads as zero. sizePages is that unit count shifted left by 14.
- R8: Stacked mode holds when boundary 7 equals top of memory. In that mode the size of rank 7 is further reduced by boundary 3, with a floor of zero.
- R9: With the strap set, channel 1 ranks are never selected. An address that only a channel 1 rank would cover gives a miss.
- R10: A rank whose computed size is zero is never selected, whatever its boundary is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 4 | Register write index |
| regWrData | input | 16 | Register write data |
| regRdAddr | input | 4 | Register read index |
| regRdData | output | 16 | Register read data, combinational |
| physAddr | input | 36 | Physical address to decode |
| sizeSel | input | 3 | Global rank whose size is reported |
| sizePages | output | 24 | Size of the selected rank in 4 KiB pages |
| hit | output | 1 | Registered: address maps to a populated rank |
| chanIdx | output | 1 | Registered channel index |
| rankIdx | output | 3 | Registered global rank index |

## Verification
If a boundary, top-of-memory or strap register held a wrong value, it would show on regRdData in the same cycle the index is selected. It would also show on sizePages for the ranks next to it, and on hit, chanIdx and rankIdx one edge after an address near that boundary is presented. An error in the stacked check or in the sizing shows up as a wrong page count for rank 7. It also shows up as a rank chosen or skipped one cycle later. For that reason the bench compares every rank size and many addresses near the boundaries for each programmed layout.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

  localparam int RBD_NUM_CH      = 2;
  localparam int RBD_RANKS_PER   = 4;
  localparam int RBD_NUM_BND     = RBD_NUM_CH * RBD_RANKS_PER;
  localparam int RBD_BND_IDX_W   = $clog2(RBD_NUM_BND);
  localparam int RBD_CH_W        = $clog2(RBD_NUM_CH);
  localparam int RBD_TOM_IDX     = RBD_NUM_BND;
  localparam int RBD_STRAP_IDX   = RBD_NUM_BND + 1;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_BND   = 2'd1,
    RD_TOM   = 2'd2,
    RD_STRAP = 2'd3
  } rbd_rd_kind_e;

  typedef struct packed {
    logic [RBD_NUM_BND-1:0]   bndWr;
    logic                     tomWr;
    logic                     strapWr;
    rbd_rd_kind_e             rdKind;
    logic [RBD_BND_IDX_W-1:0] rdBndIdx;
  } rbd_strobe_t;

endpackage

// File: rtl/rbd_ctrl.sv
module rbd_ctrl
  import rbd_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic [REG_AW-1:0] regRdAddr,
  output rbd_strobe_t       strobe
);

  always_comb begin
    strobe          = '0;
    strobe.rdKind   = RD_NONE;
    strobe.rdBndIdx = regRdAddr[RBD_BND_IDX_W-1:0];

    if (regWrEn) begin
      if (regWrAddr < REG_AW'(RBD_NUM_BND)) begin
        strobe.bndWr[regWrAddr[RBD_BND_IDX_W-1:0]] = 1'b1;
      end else if (regWrAddr == REG_AW'(RBD_TOM_IDX)) begin
        strobe.tomWr = 1'b1;
      end else if (regWrAddr == REG_AW'(RBD_STRAP_IDX)) begin
        strobe.strapWr = 1'b1;
      end
    end

    if (regRdAddr < REG_AW'(RBD_NUM_BND)) begin
      strobe.rdKind = RD_BND;
    end else if (regRdAddr == REG_AW'(RBD_TOM_IDX)) begin
      strobe.rdKind = RD_TOM;
    end else if (regRdAddr == REG_AW'(RBD_STRAP_IDX)) begin
      strobe.rdKind = RD_STRAP;
    end
  end

endmodule

// File: rtl/rbd_rank_size.sv
module rbd_rank_size #(
  parameter int BND_W = 10
) (
  input  logic [BND_W-1:0] curBnd,
  input  logic [BND_W-1:0] prevBnd,
  input  logic [BND_W-1:0] offsetBnd,
  input  logic             useOffset,
  output logic [BND_W-1:0] sizeUnits
);

  logic [BND_W-1:0] rawSize;

  always_comb begin
    rawSize = (curBnd > prevBnd) ? (curBnd - prevBnd) : '0;
    if (useOffset) begin
      sizeUnits = (rawSize > offsetBnd) ? (rawSize - offsetBnd) : '0;
    end else begin
      sizeUnits = rawSize;
    end
  end

endmodule

// File: rtl/rbd_datapath.sv
module rbd_datapath
  import rbd_pkg::*;
#(
  parameter int ADDR_W      = 36,
  parameter int GRAIN_SHIFT = 26,
  parameter int PAGE_SHIFT  = 12,
  parameter int DATA_W      = 16,
  localparam int BND_W      = ADDR_W - GRAIN_SHIFT,
  localparam int PAGE_W     = BND_W + GRAIN_SHIFT - PAGE_SHIFT
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rbd_strobe_t              strobe,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-1:0]        physAddr,
  input  logic [RBD_BND_IDX_W-1:0] sizeSel,
  output logic [DATA_W-1:0]        rdData,
  output logic [PAGE_W-1:0]        sizePages,
  output logic                     hitQ,
  output logic [RBD_CH_W-1:0]      chanQ,
  output logic [RBD_BND_IDX_W-1:0] rankQ
);

  localparam int LAST_CH0 = RBD_RANKS_PER - 1;
  localparam int LAST_ALL = RBD_NUM_BND - 1;

  logic [BND_W-1:0] bndQ [RBD_NUM_BND];
  logic [BND_W-1:0] tomQ;
  logic             singleQ;
  logic [BND_W-1:0] sizeUnits [RBD_NUM_BND];
  logic             stacked;
  logic [BND_W-1:0] addrUnits;

  // Register storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RBD_NUM_BND; i++) bndQ[i] <= '0;
      tomQ    <= '0;
      singleQ <= 1'b0;
    end else begin
      for (int i = 0; i < RBD_NUM_BND; i++) begin
        if (strobe.bndWr[i]) bndQ[i] <= wrData[BND_W-1:0];
      end
      if (strobe.tomWr)   tomQ    <= wrData[BND_W-1:0];
      if (strobe.strapWr) singleQ <= wrData[0];
    end
  end

  assign stacked = (bndQ[LAST_ALL] == tomQ);

  // Per-rank sizing
  for (genvar gi = 0; gi < RBD_NUM_BND; gi++) begin : g_size
    logic [BND_W-1:0] prevBnd;
    logic             useOffset;
    if ((gi % RBD_RANKS_PER) == 0) begin : g_first
      assign prevBnd = '0;
    end else begin : g_next
      assign prevBnd = bndQ[gi-1];
    end
    if (gi == LAST_ALL) begin : g_stack
      assign useOffset = stacked;
    end else begin : g_plain
      assign useOffset = 1'b0;
    end
    rbd_rank_size #(.BND_W(BND_W)) size_i (
      .curBnd    (bndQ[gi]),
      .prevBnd   (prevBnd),
      .offsetBnd (bndQ[LAST_CH0]),
      .useOffset (useOffset),
      .sizeUnits (sizeUnits[gi])
    );
  end

  assign sizePages = {sizeUnits[sizeSel], {(GRAIN_SHIFT-PAGE_SHIFT){1'b0}}};

  // Read-back mux
  always_comb begin
    rdData = '0;
    unique case (strobe.rdKind)
      RD_BND:   rdData = {{(DATA_W-BND_W){1'b0}}, bndQ[strobe.rdBndIdx]};
      RD_TOM:   rdData = {{(DATA_W-BND_W){1'b0}}, tomQ};
      RD_STRAP: rdData = {{(DATA_W-1){1'b0}}, singleQ};
      default:  rdData = '0;
    endcase
  end

  // Address decode
  logic                     decFound;
  logic [RBD_BND_IDX_W-1:0] decIdx;
  logic                     decHit;
  logic [RBD_NUM_BND-1:0]   candidate;

  assign addrUnits = physAddr[ADDR_W-1:GRAIN_SHIFT];

  always_comb begin
    for (int i = 0; i < RBD_NUM_BND; i++) begin
      candidate[i] = (addrUnits < bndQ[i]) && (sizeUnits[i] != '0) &&
                     ((i < RBD_RANKS_PER) || !singleQ);
    end
    decFound = 1'b0;
    decIdx   = '0;
    for (int i = 0; i < RBD_NUM_BND; i++) begin
      if (!decFound && candidate[i]) begin
        decFound = 1'b1;
        decIdx   = RBD_BND_IDX_W'(i);
      end
    end
    decHit = decFound && (addrUnits < tomQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ  <= 1'b0;
      chanQ <= '0;
      rankQ <= '0;
    end else begin
      hitQ  <= decHit;
      chanQ <= decHit ? decIdx[RBD_BND_IDX_W-1 -: RBD_CH_W] : '0;
      rankQ <= decHit ? decIdx : '0;
    end
  end

  // Checks next to the logic they guard
  AST_MISS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !hitQ |-> (chanQ == '0 && rankQ == '0)); // R6

  AST_TOM_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (addrUnits >= tomQ) |=> !hitQ); // R6

  AST_SINGLE_CH0: assert property (@(posedge clk) disable iff (!rstN)
    singleQ |=> (chanQ == '0)); // R9

  AST_RANK_CHAN: assert property (@(posedge clk) disable iff (!rstN)
    hitQ |-> (rankQ[RBD_BND_IDX_W-1] == chanQ[0])); // R4

  AST_TOM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tomWr |=> (tomQ == $past(wrData[BND_W-1:0]))); // R1

  AST_SIZE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (sizeUnits[0] == bndQ[0])); // R7

endmodule

// File: rtl/dram_rank_decoder.sv
module dram_rank_decoder
  import rbd_pkg::*;
#(
  parameter int ADDR_W      = 36,
  parameter int GRAIN_SHIFT = 26,
  parameter int PAGE_SHIFT  = 12,
  parameter int DATA_W      = 16,
  parameter int REG_AW      = 4,
  localparam int BND_W      = ADDR_W - GRAIN_SHIFT,
  localparam int PAGE_W     = BND_W + GRAIN_SHIFT - PAGE_SHIFT
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic [REG_AW-1:0]        regWrAddr,
  input  logic [DATA_W-1:0]        regWrData,
  input  logic [REG_AW-1:0]        regRdAddr,
  output logic [DATA_W-1:0]        regRdData,
  input  logic [ADDR_W-1:0]        physAddr,
  input  logic [RBD_BND_IDX_W-1:0] sizeSel,
  output logic [PAGE_W-1:0]        sizePages,
  output logic                     hit,
  output logic [RBD_CH_W-1:0]      chanIdx,
  output logic [RBD_BND_IDX_W-1:0] rankIdx
);

  rbd_strobe_t strobe;

  rbd_ctrl #(.REG_AW(REG_AW)) ctrl_i (
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .regRdAddr (regRdAddr),
    .strobe    (strobe)
  );

  rbd_datapath #(
    .ADDR_W      (ADDR_W),
    .GRAIN_SHIFT (GRAIN_SHIFT),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .DATA_W      (DATA_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .physAddr  (physAddr),
    .sizeSel   (sizeSel),
    .rdData    (regRdData),
    .sizePages (sizePages),
    .hitQ      (hit),
    .chanQ     (chanIdx),
    .rankQ     (rankIdx)
  );

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:BND_W] == '0); // R1

endmodule

// File: tb/dram_rank_decoder_tb_top.sv
`timescale 1ns/1ps
module dram_rank_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regWrAddr = '0;
  logic [15:0] regWrData = '0;
  logic [3:0]  regRdAddr = '0;
  logic [15:0] regRdData;
  logic [35:0] physAddr = '0;
  logic [2:0]  sizeSel = '0;
  logic [23:0] sizePages;
  logic        hit;
  logic        chanIdx;
  logic [2:0]  rankIdx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench-side model state
  int unsigned mBnd [8];
  int unsigned mTom;
  bit          mSingle;

  always #10 clk = ~clk;

  dram_rank_decoder dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .physAddr(physAddr), .sizeSel(sizeSel), .sizePages(sizePages),
    .hit(hit), .chanIdx(chanIdx), .rankIdx(rankIdx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned expUnits(input int idx);
    int unsigned prev, d;
    prev = (idx % 4 == 0) ? 0 : mBnd[idx-1];
    d = (mBnd[idx] > prev) ? mBnd[idx] - prev : 0;
    if (idx == 7 && mBnd[7] == mTom) d = (d > mBnd[3]) ? d - mBnd[3] : 0;
    return d;
  endfunction

  function automatic logic [4:0] expDecode(input int unsigned u);
    if (u >= mTom) return 5'b0;
    for (int i = 0; i < 8; i++) begin
      if (u < mBnd[i] && expUnits(i) != 0 && (i < 4 || !mSingle))
        return {1'b1, 1'(i / 4), 3'(i)};
    end
    return 5'b0;
  endfunction

  task automatic wrReg(input int idx, input int unsigned val);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = 4'(idx); regWrData = 16'(val);
    @(negedge clk);
    regWrEn = 1'b0;
    if (idx < 8) mBnd[idx] = val & 32'h3ff;
    else if (idx == 8) mTom = val & 32'h3ff;
    else if (idx == 9) mSingle = val[0];
  endtask

  task automatic loadCfg(input int unsigned b[8], input int unsigned tom, input bit single);
    for (int i = 0; i < 8; i++) wrReg(i, b[i]);
    wrReg(8, tom);
    wrReg(9, {31'b0, single});
  endtask

  // drive at a negedge, sample at the following negedge
  task automatic decodeChk(input int unsigned u, input string req);
    logic [4:0] e;
    physAddr = {10'(u), 26'($urandom)};
    @(negedge clk);
    e = expDecode(u);
    chk(req, {hit, chanIdx, rankIdx}, e);
  endtask

  task automatic sizesChk(input string req);
    for (int i = 0; i < 8; i++) begin
      sizeSel = 3'(i);
      #1;
      chk(req, sizePages, 64'(expUnits(i)) << 14);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned cfg[8];
    int unsigned acc;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) mBnd[i] = 0;
    mTom = 0; mSingle = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2: reset state
    chk("R2 hit", hit, 0); chk("R2 chan", chanIdx, 0); chk("R2 rank", rankIdx, 0);
    for (int i = 0; i < 10; i++) begin
      regRdAddr = 4'(i); #1; chk("R2 regs", regRdData, 0);
    end
    sizesChk("R2 sizes");
    decodeChk(0, "R2 decode");

    // R1: readback masking and unused index
    wrReg(0, 16'hffff); regRdAddr = 0; #1; chk("R1 bnd mask", regRdData, 16'h03ff);
    wrReg(9, 16'hfffe); regRdAddr = 9; #1; chk("R1 strap bit0", regRdData, 0);
    wrReg(9, 16'hffff); regRdAddr = 9; #1; chk("R1 strap", regRdData, 1);
    wrReg(8, 16'hfc15); regRdAddr = 8; #1; chk("R1 tom", regRdData, 16'h0015);
    wrReg(14, 16'h0123); regRdAddr = 14; #1; chk("R1 unused", regRdData, 0);

    // R8: stacked layout, rank 7 offset by channel 0 total
    cfg = '{2, 4, 6, 8, 10, 12, 14, 24};
    loadCfg(cfg, 24, 0);
    sizeSel = 7; #1; chk("R8 stacked size", sizePages, 24'd32768);
    decodeChk(20, "R8 stacked decode");
    chk("R8 rank7", rankIdx, 7);
    wrReg(8, 30);
    sizeSel = 7; #1; chk("R7 unstacked size", sizePages, 24'd163840);

    // R6: top of memory edge
    wrReg(8, 24);
    decodeChk(23, "R6 below tom");
    chk("R6 below tom hit", hit, 1);
    decodeChk(24, "R6 at tom");
    chk("R6 at tom miss", hit, 0);

    // R10: stacked size floor gives a zero rank that is skipped
    cfg = '{2, 2, 6, 8, 10, 12, 20, 24};
    loadCfg(cfg, 24, 0);
    sizeSel = 7; #1; chk("R10 zero size", sizePages, 0);
    decodeChk(22, "R10 skip zero rank");
    chk("R10 miss", hit, 0);
    decodeChk(1, "R5 rank0");
    decodeChk(3, "R10 equal boundary");
    chk("R10 rank2", rankIdx, 2);
    sizesChk("R7 sizes");

    // R9: single-channel strap
    wrReg(9, 1);
    decodeChk(9, "R9 ch1 ignored");
    chk("R9 miss", hit, 0);
    decodeChk(5, "R9 ch0 still");
    wrReg(9, 0);
    decodeChk(9, "R9 ch1 back");
    chk("R9 ch1 hit", chanIdx, 1);

    // R3: write used by the next decode; output holds until next edge
    wrReg(8, 8);
    decodeChk(10, "R3 before write");
    chk("R3 miss", hit, 0);
    wrReg(8, 24);
    decodeChk(10, "R3 write then decode");
    chk("R3 hit", hit, 1);
    physAddr = {10'd30, 26'd0};
    #2;
    chk("R3 latency hold", hit, 1);
    @(negedge clk);
    chk("R3 after edge", hit, 0);

    // R4 R5 R7: random layouts and addresses
    for (int c = 0; c < 40; c++) begin
      acc = 0;
      for (int i = 0; i < 8; i++) begin
        if (i == 4 && $urandom_range(1, 0) == 0) acc = 0;
        acc = acc + $urandom_range(3, 0);
        cfg[i] = acc;
      end
      loadCfg(cfg, ($urandom_range(2, 0) == 0) ? cfg[7] : $urandom_range(cfg[7] + 2, 0),
              ($urandom_range(3, 0) == 0));
      sizesChk("R7 random sizes");
      for (int k = 0; k < 25; k++) begin
        decodeChk($urandom_range(cfg[7] + 3, 0), "R5 random decode");
        if (hit) chk("R4 rank vs chan", rankIdx[2], chanIdx);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule